// File: doc/BRIEF.md
# Bidirectional Barrel Shifter

This block shifts or rotates a data word by 0 to 2^S-1 positions in a single pass, where S is log2 of the word width. It contains two logarithmic shifter ranks that work side by side: one moves bits toward the MSB and one moves bits toward the LSB. Each rank is a chain of stages that move by 1, 2, 4, ... positions. Each stage is enabled by one bit of the shift amount, so the logic depth grows with log2 of the width. A final multiplexer picks which rank's output becomes the result.

The control word holds the shift amount in its low S bits and the direction in its top bit. With the rotate enable low, a left shift fills with zeros and a right shift is arithmetic. With the rotate enable high, the bits that leave one end come back in at the other end. An optional output register, enabled by default, makes the result available one clock after the inputs.

Top module: `bshift_unit`

## Requirements
- R1: With ctrl[3]=1 and rot_en=0, result equals data_in shifted left by ctrl[2:0] positions, with zeros entering the vacated low bits.
- R2: With ctrl[3]=0 and rot_en=0, result equals data_in shifted right by ctrl[2:0] positions, with copies of data_in[7] entering the vacated high bits.
- R3: With ctrl[3]=1 and rot_en=1, result equals data_in rotated left by ctrl[2:0], so bits leaving bit 7 re-enter at bit 0.
- R4: With ctrl[3]=0 and rot_en=1, result equals data_in rotated right by ctrl[2:0], so bits leaving bit 0 re-enter at bit 7 and no sign fill occurs.
- R5: A shift amount of ctrl[2:0]=0 passes data_in through unchanged for both directions and both values of rot_en.
- R6: With the default output register, result takes the value computed from the inputs present at a rising clock edge and holds it until the next edge; while rst_n is low, result is 0.
- R7: An arithmetic right shift by 7 without rotate gives all ones for a negative word (data_in[7]=1) and all zeros for a non-negative word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| data_in | input | 8 | Word to shift or rotate |
| ctrl | input | 4 | Bits [2:0] give the shift amount; bit 3 = 1 gives left, 0 gives right |
| rot_en | input | 1 | 1 = wrap shifted-out bits around, 0 = fill with constants |
| result | output | 8 | Shifted or rotated word |

## Verification
All sixteen control codes are swept, each with rotate on and with rotate off, on two data words. One word has its top bit set and the other has it clear, so sign fill can be told apart from zero fill, and rotation from plain shifting. Seeded random words and controls then exercise mixed bit patterns in every stage combination. The reference model uses the language's shift operators. Each check also samples the output just before the next edge, to confirm that it holds the previous value for one cycle.

// File: rtl/bshift_unit.sv
module bshift_unit #(
  parameter int W       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] data_in,
  input  logic [$clog2(W):0] ctrl,
  input  logic         rot_en,
  output logic [W-1:0] result
);
  localparam int SW = $clog2(W);

  logic [W-1:0] lv [SW+1];
  logic [W-1:0] rv [SW+1];
  logic [W-1:0] res_c;
  logic         go_left;

  assign go_left = ctrl[SW];
  assign lv[0]   = data_in;
  assign rv[0]   = data_in;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int D = 1 << s;
    logic [D-1:0] lfill, rfill;
    assign lfill = rot_en ? lv[s][W-1:W-D] : '0;
    assign rfill = rot_en ? rv[s][D-1:0]   : {D{rv[s][W-1]}};
    assign lv[s+1] = ctrl[s] ? {lv[s][W-1-D:0], lfill} : lv[s];
    assign rv[s+1] = ctrl[s] ? {rfill, rv[s][W-1:D]}   : rv[s];
  end

  assign res_c = go_left ? lv[SW] : rv[SW];

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) result <= '0;
      else        result <= res_c;
    end

    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[SW-1:0] == '0) |=> (result == $past(data_in))); // R5
    AST_LEFT_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (go_left && !rot_en && ctrl[SW-1:0] != '0) |=> (result[0] == 1'b0)); // R1
    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!go_left && !rot_en) |=> (result[W-1] == $past(data_in[W-1]))); // R2
    AST_ROT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      rot_en |=> ($countones(result) == $countones($past(data_in)))); // R3
    AST_ROTR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (rot_en && !go_left) |=> ($countones(result) == $countones($past(data_in)))); // R4
    AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |-> (result == '0)); // R6
  end else begin : g_comb
    assign result = res_c;
  end
endmodule

// File: tb/bshift_unit_bench.sv
module bshift_unit_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] data_in = '0;
  logic [3:0]   ctrl = '0;
  logic         rot_en = 1'b0;
  logic [W-1:0] result;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] prev_exp = '0;
  bit done = 0;

  always #10 clk = ~clk;

  bshift_unit u_bshift_unit (
    .clk(clk), .rst_n(rst_n), .data_in(data_in),
    .ctrl(ctrl), .rot_en(rot_en), .result(result)
  );

  function automatic logic [W-1:0] ref_model(logic [W-1:0] d, logic [3:0] c, logic r);
    int a = int'(c[2:0]);
    if (r) begin
      if (c[3]) return (d << a) | (d >> (W - a));
      else      return (d >> a) | (d << (W - a));
    end
    if (c[3]) return d << a;
    return W'($signed(d) >>> a);
  endfunction

  function automatic string req_of(logic [3:0] c, logic r);
    if (c[2:0] == 3'd0) return "R5";
    if (r) return c[3] ? "R3" : "R4";
    if (c[3]) return "R1";
    if (c[2:0] == 3'd7) return "R7";
    return "R2";
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: result=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [W-1:0] d, logic [3:0] c, logic r);
    logic [W-1:0] e;
    @(negedge clk);
    data_in = d; ctrl = c; rot_en = r;
    e = ref_model(d, c, r);
    #2;
    check("R6", result, prev_exp);
    @(negedge clk);
    check(req_of(c, r), result, e);
    prev_exp = e;
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (2) @(negedge clk);
    check("R6", result, '0);
    data_in = 8'hFF; ctrl = 4'hB;
    @(negedge clk);
    check("R6", result, '0);
    rst_n = 1'b1;
    prev_exp = '0;
    data_in = '0; ctrl = '0;
    @(negedge clk);
    prev_exp = '0;
    foreach (data_in[i]) begin end
    for (int di = 0; di < 2; di++) begin
      for (int r = 0; r < 2; r++) begin
        for (int c = 0; c < 16; c++) begin
          apply(di == 0 ? 8'hB5 : 8'h4A, 4'(c), r[0]);
        end
      end
    end
    apply(8'h80, 4'h7, 1'b0); // R7 negative
    apply(8'h7F, 4'h7, 1'b0); // R7 non-negative
    apply(8'h01, 4'hF, 1'b0); // R1 bit 0 reaches bit 7
    apply(8'h01, 4'hF, 1'b1); // R3 wrap
    apply(8'h80, 4'h7, 1'b1); // R4 wrap
    for (int k = 0; k < 400; k++) begin
      apply(W'($urandom), 4'($urandom), 1'($urandom));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule